// File: doc/BRIEF.md
# SPI Double-Buffered Data Path

This block is the data side of a master SPI port. A processor reaches it through a one-bit register address. Address 0 returns a status byte. Address 1 is the data address: a write goes into a transmit holding buffer, and a read returns a separate receive buffer. Between the two buffers sits a shifter. It sends one byte on `mosi` and collects one byte from `miso` in the same transfer. An external baud generator supplies `sck_tick`, a single-cycle strobe for every half period of the serial clock.

The edge between processor and port is throttled by two flags rather than by a valid/ready pair. "Transmit empty" plays the role of ready for the outgoing byte stream. The processor must read status and see that flag set before a data write is taken; any other data write is dropped. "Receive full" plays the role of valid for the incoming stream. It has no back-pressure: a byte that finishes while the previous one is still unread is lost. Both flags drive interrupt requests through their own enables. Dropping `en` aborts everything and returns the block to its empty state.

Top module: `spi_dbuf_dp`

## Requirements
- R1: While `en` is low and right after reset, the status byte reads 0x20. Status bit 7 is receive full and bit 5 is transmit empty; all other status bits read 0. `sck_out` equals `cpol`.
- R2: A write to address 1 loads the transmit buffer. A read of address 1 returns the receive buffer, never the byte last written.
- R3: A data write is taken only when it follows a status read that saw transmit empty set. Any other data write is ignored: no transfer starts and transmit empty stays set.
- R4: With the shifter idle, an accepted byte moves to the shifter on the next cycle. Transmit empty reads 0 in the cycle after the write and 1 again in the cycle after that.
- R5: A byte written while a transfer runs waits in the buffer with transmit empty clear. It starts by itself once the running transfer ends, and transmit empty sets at that move.
- R6: Receive full sets when a transfer ends. It clears only through a status read that sees it set, followed by a data read; a data read without that status read leaves it set.
- R7: A transfer that ends while receive full is set leaves the receive buffer unchanged, so the new byte is lost.
- R8: Driving `en` low aborts the transfer in progress, discards both buffers, clears receive full and sets transmit empty.
- R9: `irq_rx` is receive full AND `rx_ie`; `irq_tx` is transmit empty AND `tx_ie`.
- R10: With `lsb_first` high, bit 0 is sent and received first; otherwise bit 7 goes first.
- R11: A byte takes 16 `sck_tick` strobes, each toggling `sck_out`, with idle level `cpol`. With `cpha` 0, bits are sampled on leading edges and change on trailing edges. With `cpha` 1, bits change on leading edges after the first and are sampled on trailing edges.
- R12: Each transfer shifts one full byte out on `mosi` while shifting one full byte in from `miso`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low aborts and empties |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Selects the edge pair used to sample and change data |
| lsb_first | input | 1 | Shift bit 0 first when high |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| cpu_addr | input | 1 | 0 = status, 1 = data |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe (arms flag clears) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data for the addressed register |
| sck_tick | input | 1 | Half-period strobe from the baud generator |
| sck_out | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
A bench-side slave follows `sck_out` and scores every byte it sees on `mosi` against a queue. It answers with its own queued bytes, which the processor side then reads back. The transfer is run in all eight combinations of polarity, phase and bit order. The bytes are chosen so that they are not palindromes under bit reversal, so each combination gives a different waveform and any mix-up of edge or order shows. Further patterns separate the flag behaviour: a data write without a status read, a second byte queued behind a running transfer, a transfer that ends into an unread buffer, a data read without the status read that arms it, and a disable in mid-byte. Each of these must differ from a plain single transfer in exactly the way its requirement states.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_DATA   = 1'b1
  } reg_sel_e;

  localparam int unsigned ST_RXFULL_POS  = 7;
  localparam int unsigned ST_TXEMPTY_POS = 5;
endpackage

// File: rtl/spi_dbuf_regs.sv
module spi_dbuf_regs
  import spi_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              ld_go,
  input  logic              sh_done,
  input  logic [DATA_W-1:0] sh_rx,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_buf,
  output logic [DATA_W-1:0] rx_buf
);
  logic tx_arm, rx_arm;
  logic stat_rd, data_wr, data_rd, wr_take, rd_clear;

  assign stat_rd  = cpu_rd && (cpu_addr == REG_STATUS);
  assign data_wr  = cpu_wr && (cpu_addr == REG_DATA);
  assign data_rd  = cpu_rd && (cpu_addr == REG_DATA);
  assign wr_take  = data_wr && tx_arm && tx_empty;
  assign rd_clear = data_rd && rx_arm && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      tx_valid <= 1'b0;
      tx_arm   <= 1'b0;
      rx_arm   <= 1'b0;
      tx_buf   <= '0;
      rx_buf   <= '0;
    end else if (!en) begin
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      tx_valid <= 1'b0;
      tx_arm   <= 1'b0;
      rx_arm   <= 1'b0;
      tx_buf   <= '0;
      rx_buf   <= '0;
    end else begin
      if (stat_rd) begin
        tx_arm <= tx_empty;
        rx_arm <= rx_full;
      end
      // transmit side: accept from the processor, hand over to the shifter
      if (wr_take) begin
        tx_buf   <= cpu_wdata;
        tx_valid <= 1'b1;
        tx_empty <= 1'b0;
        tx_arm   <= 1'b0;
      end else if (ld_go) begin
        tx_valid <= 1'b0;
        tx_empty <= 1'b1;
      end
      // receive side: a finished byte is kept only if the buffer is free
      if (sh_done && !rx_full) begin
        rx_buf  <= sh_rx;
        rx_full <= 1'b1;
      end else if (rd_clear) begin
        rx_full <= 1'b0;
        rx_arm  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_dbuf_shifter.sv
module spi_dbuf_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              sck_tick,
  input  logic              ld_go,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              mosi,
  output logic              sck_out
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned HW    = $clog2(EDGES);
  localparam logic [HW-1:0] LAST_EDGE = HW'(EDGES - 1);

  logic [HW-1:0]     hcnt;
  logic              sck_int;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_nxt, tx_nxt;
  logic              lead, last, do_samp, do_adv;

  assign lead    = ~hcnt[0];
  assign last    = (hcnt == LAST_EDGE);
  assign do_samp = cpha ? ~lead : lead;
  assign do_adv  = cpha ? (lead && (hcnt != '0)) : (~lead && !last);

  always_comb begin
    if (lsb_first) begin
      rx_nxt = {miso, rx_sh[DATA_W-1:1]};
      tx_nxt = {1'b0, tx_sh[DATA_W-1:1]};
    end else begin
      rx_nxt = {rx_sh[DATA_W-2:0], miso};
      tx_nxt = {tx_sh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      hcnt    <= '0;
      sck_int <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else if (!en) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      hcnt    <= '0;
      sck_int <= 1'b0;
      tx_sh   <= '0;
    end else begin
      done <= 1'b0;
      if (ld_go) begin
        busy    <= 1'b1;
        hcnt    <= '0;
        sck_int <= 1'b0;
        tx_sh   <= ld_data;
      end else if (busy && sck_tick) begin
        sck_int <= ~sck_int;
        if (do_samp) rx_sh <= rx_nxt;
        if (do_adv)  tx_sh <= tx_nxt;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          hcnt <= '0;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  assign rx_byte = rx_sh;
  assign mosi    = lsb_first ? tx_sh[0] : tx_sh[DATA_W-1];
  assign sck_out = cpol ^ sck_int;
endmodule

// File: rtl/spi_dbuf_dp.sv
module spi_dbuf_dp
  import spi_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              rx_ie,
  input  logic              tx_ie,
  input  logic              cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              sck_tick,
  output logic              sck_out,
  output logic              mosi,
  input  logic              miso,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic              tx_empty_w, rx_full_w, tx_valid_w, busy_w, done_w, ld_go_w;
  logic [DATA_W-1:0] tx_buf_w, rx_buf_w, sh_rx_w, status_w;

  assign ld_go_w = en && tx_valid_w && !busy_w;

  spi_dbuf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .ld_go(ld_go_w), .sh_done(done_w), .sh_rx(sh_rx_w),
    .tx_empty(tx_empty_w), .rx_full(rx_full_w), .tx_valid(tx_valid_w),
    .tx_buf(tx_buf_w), .rx_buf(rx_buf_w)
  );

  spi_dbuf_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .sck_tick(sck_tick),
    .ld_go(ld_go_w), .ld_data(tx_buf_w), .miso(miso),
    .busy(busy_w), .done(done_w), .rx_byte(sh_rx_w),
    .mosi(mosi), .sck_out(sck_out)
  );

  always_comb begin
    status_w = '0;
    status_w[ST_RXFULL_POS]  = rx_full_w;
    status_w[ST_TXEMPTY_POS] = tx_empty_w;
  end

  assign cpu_rdata = (cpu_addr == REG_DATA) ? rx_buf_w : status_w;
  assign irq_rx    = rx_full_w && rx_ie;
  assign irq_tx    = tx_empty_w && tx_ie;
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cpol,
  input logic              cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              sck_out,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              tx_valid,
  input logic              busy,
  input logic              sh_done,
  input logic [DATA_W-1:0] rx_buf
);
  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_empty && !rx_full && !busy));

  p_idle_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sck_out == cpol));

  p_txe_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(cpu_wr && cpu_addr));

  p_rxf_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past((cpu_rd && cpu_addr) || !en));

  p_rxf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sh_done && !rx_full) |=> rx_full);

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sh_done && rx_full) |=> $stable(rx_buf));

  p_handover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tx_valid && !busy) |=> (busy && tx_empty));
endmodule

bind spi_dbuf_dp spi_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol),
  .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .sck_out(sck_out),
  .tx_empty(tx_empty_w), .rx_full(rx_full_w), .tx_valid(tx_valid_w),
  .busy(busy_w), .sh_done(done_w), .rx_buf(rx_buf_w)
);

// File: tb/spi_dbuf_dp_tb.sv
module spi_dbuf_dp_tb;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0, rx_ie = 1'b0, tx_ie = 1'b0;
  logic cpu_addr = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'h00, cpu_rdata;
  logic sck_tick = 1'b0, sck_out, mosi, miso = 1'b0, irq_rx, irq_tx;

  int n_chk = 0, n_bad = 0, tick_cnt = 0, edges_total = 0;
  bit finished = 1'b0;
  logic [7:0] exp_mosi_q[$];
  logic [7:0] miso_q[$];

  always #10 clk = ~clk;

  spi_dbuf_dp u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .rx_ie(rx_ie), .tx_ie(tx_ie),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sck_tick(sck_tick), .sck_out(sck_out), .mosi(mosi), .miso(miso),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % 4;
    sck_tick <= (tick_cnt == 0);
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic int bpos(int i);
    return lsb_first ? i : 7 - i;
  endfunction

  // bench-side slave and scoreboard monitor
  logic [7:0] s_cur, s_rx;
  int s_ecnt = 0, s_scnt = 0, s_idx = 0;
  bit s_have = 1'b0;
  logic s_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst_n || !en) begin
      s_ecnt = 0; s_scnt = 0; s_have = 1'b0; s_prev = sck_out;
    end else begin
      if (!s_have && miso_q.size() > 0 && s_ecnt == 0) begin
        s_cur = miso_q.pop_front(); s_have = 1'b1; s_idx = 0; s_rx = 8'h00;
        miso <= s_cur[bpos(0)];
      end
      if (sck_out != s_prev) begin
        automatic bit lead = (s_ecnt % 2) == 0;
        automatic bit samp = cpha ? !lead : lead;
        automatic bit adv  = cpha ? (lead && s_ecnt > 0) : (!lead && s_ecnt < 15);
        edges_total++;
        if (samp) begin s_rx[bpos(s_scnt)] = mosi; s_scnt++; end
        if (adv) begin s_idx++; miso <= s_cur[bpos(s_idx)]; end
        s_ecnt++;
        if (s_ecnt == 16) begin
          if (exp_mosi_q.size() > 0) check("R12/R10/R11 mosi byte", s_rx, exp_mosi_q.pop_front());
          else check("R12 unexpected transfer", s_rx, 8'hxx);
          s_ecnt = 0; s_scnt = 0; s_have = 1'b0;
        end
      end
      s_prev = sck_out;
    end
  end

  task automatic cpu_read(logic a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1; #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic cpu_write(logic a, logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic peek(output logic [7:0] st);
    cpu_addr = 1'b0; #1 st = cpu_rdata;
  endtask

  task automatic xfer(logic [7:0] tx, logic [7:0] resp);
    logic [7:0] d;
    miso_q.push_back(resp); exp_mosi_q.push_back(tx);
    cpu_read(1'b0, d);
    cpu_write(1'b1, tx);
  endtask

  task automatic fetch(output logic [7:0] d);
    logic [7:0] s;
    cpu_read(1'b0, s);
    cpu_read(1'b1, d);
  endtask

  task automatic set_mode(logic p, logic h, logic l);
    @(negedge clk); en = 1'b0;
    @(negedge clk); cpol = p; cpha = h; lsb_first = l;
    exp_mosi_q.delete(); miso_q.delete();
    @(negedge clk); en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, d;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    peek(st);
    check("R1 reset status", st, 8'h20);
    check("R1 idle sck", {7'd0, sck_out}, {7'd0, cpol});
    check("R9 irq_tx off when disabled", {7'd0, irq_tx}, 8'h00);

    // R3: data write without a status read is dropped
    e0 = edges_total;
    cpu_write(1'b1, 8'h5A);
    repeat (90) @(negedge clk);
    peek(st);
    check("R3 unarmed write status", st, 8'h20);
    check("R3 no edges", 8'(edges_total - e0), 8'h00);

    // R4: idle hand-over timing, then R2/R6/R12 readback
    miso_q.push_back(8'h3C); exp_mosi_q.push_back(8'hA5);
    cpu_read(1'b0, st);
    cpu_write(1'b1, 8'hA5);
    peek(st); check("R4 tx_empty low one cycle", st, 8'h00);
    @(negedge clk); peek(st); check("R4 tx_empty back high", st, 8'h20);
    repeat (90) @(negedge clk);
    peek(st); check("R6 rx_full set", st, 8'hA0);
    fetch(d); check("R2/R12 rx byte", d, 8'h3C);
    peek(st); check("R6 rx_full cleared", st, 8'h20);

    // R6: data read without arming status read keeps the flag
    xfer(8'h11, 8'h22);
    repeat (90) @(negedge clk);
    cpu_read(1'b1, d);
    peek(st); check("R6 unarmed read keeps flag", st, 8'hA0);
    fetch(d); check("R6 armed read data", d, 8'h22);

    // R7: overrun drops the second byte
    xfer(8'h33, 8'h44);
    repeat (90) @(negedge clk);
    xfer(8'h55, 8'h66);
    repeat (90) @(negedge clk);
    fetch(d); check("R7 overrun keeps first", d, 8'h44);
    peek(st); check("R7 flag cleared", st, 8'h20);

    // R5: queued byte follows automatically
    xfer(8'h81, 8'h18);
    repeat (3) @(negedge clk);
    xfer(8'h7E, 8'hE7);
    peek(st); check("R5 queued tx_empty low", st, 8'h00);
    repeat (160) @(negedge clk);
    peek(st); check("R5 both sent", st, 8'hA0);
    fetch(d); check("R5 first rx kept", d, 8'h18);

    // R10/R11: all polarity/phase/order combinations
    for (int m = 0; m < 8; m++) begin
      logic [7:0] tx, rsp;
      tx = 8'h1D + 8'(m * 16); rsp = 8'hC4 ^ 8'(m * 3);
      set_mode(m[0], m[1], m[2]);
      peek(st); check("R1 idle sck per mode", {7'd0, sck_out}, {7'd0, m[0]});
      xfer(tx, rsp);
      repeat (90) @(negedge clk);
      fetch(d); check("R10/R11 rx byte per mode", d, rsp);
    end

    // R9: interrupt requests
    tx_ie = 1'b1; rx_ie = 1'b1;
    @(negedge clk);
    check("R9 irq_tx", {7'd0, irq_tx}, 8'h01);
    check("R9 irq_rx idle", {7'd0, irq_rx}, 8'h00);
    xfer(8'h6B, 8'hB6);
    repeat (90) @(negedge clk);
    check("R9 irq_rx set", {7'd0, irq_rx}, 8'h01);
    fetch(d);
    check("R9 irq_rx cleared", {7'd0, irq_rx}, 8'h00);

    // R8: abort mid-transfer
    xfer(8'hC3, 8'h3C);
    repeat (3) @(negedge clk);
    xfer(8'h0F, 8'hF0);
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    exp_mosi_q.delete(); miso_q.delete();
    peek(st); check("R8 abort status", st, 8'h20);
    check("R8 abort sck idle", {7'd0, sck_out}, {7'd0, cpol});
    check("R8 irq_tx after abort", {7'd0, irq_tx}, 8'h01);
    e0 = edges_total;
    en = 1'b1;
    repeat (150) @(negedge clk);
    check("R8 no resumed transfer", 8'(edges_total - e0), 8'h00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule